// File: doc/BRIEF.md
# SPI NOR Flash Slave Model

This block is a synthesizable serial NOR flash placed behind an SPI target port. A host drives a serial clock, an active-low select and a data-in line, and reads back a data-out line. Every command starts with a one-byte opcode. Commands that take an address follow it with three address bytes, most significant byte first. The storage array is organised as two erase blocks. Each block holds eight erase sectors, and each sector holds a set of program pages. Programming can only clear bits. Erasure works only on a whole sector, a whole block or the whole array, and it sets bytes to FFh.

The serial lines pass through two-flop synchronisers into the system clock domain. The serial clock must therefore run well below the system clock, and select must settle a few system clocks before the first serial edge. Program and erase operations start when select rises. A busy flag then holds for a set number of system clocks. While the flag is set, the host can only poll status. The sizes are parameters given as power-of-two address widths. The full-size organisation is a 16-bit address, 12-bit sectors, 15-bit blocks and 8-bit pages. The defaults are a reduced copy with the same shape: 512 bytes, 32-byte sectors, 256-byte blocks and 8-byte pages.

Top module: `nor_flash_spi`

## Requirements
- R1: After reset the status byte reads 00h and every array byte reads FFh.
- R2: Data-in is sampled on rising serial clock edges and data-out changes on falling edges, both most significant bit first. Transfers work with the serial clock idling low or idling high while deselected.
- R3: Opcode 06h sets the write-enable latch. Opcode 05h streams the live status byte repeatedly: bit 0 is busy, bit 1 is the write-enable latch, and the other bits are 0.
- R4: Opcode 03h with a 3-byte address streams bytes from that address onward, using only the low ADDR_W address bits. Past the top address the read wraps to address 0.
- R5: Opcode 02h with a 3-byte address writes the bitwise AND of the stored byte and each data byte. Bytes beyond the end of the page wrap to the start of the same page.
- R6: Opcode 20h erases the sector holding the address, D8h erases the block holding the address, and C7h erases the whole array. Each erase sets every byte in its range to FFh.
- R7: Program and erase commands have no effect when the write-enable latch is clear.
- R8: An accepted program or erase sets busy when select rises. Busy holds for BUSY_CYCLES system clocks, then clears together with the write-enable latch.
- R9: While busy, every opcode except 05h is ignored and the block returns 00h on data-out.
- R10: An erase is performed only when select rises after exactly 4 bytes (20h, D8h) or exactly 1 byte (C7h). A program needs at least one data byte. Any other length has no effect and leaves the latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select |
| spi_di | input | 1 | Serial data from the host |
| spi_do | output | 1 | Serial data to the host, 0 while deselected |

## Verification
The bench builds the block with ADDR_W 9, SECTOR_W 5, BLOCK_W 8, PAGE_W 3 and BUSY_CYCLES 400. This keeps the 2-block, 16-sector layout but makes the array only 512 bytes. At that size one read sweep crosses the top-to-zero wrap and compares every byte against an arithmetic model after a program into each sector, a sector erase and a block erase. The busy window is long enough for a single status stream to show busy in its first byte and cleared in its seventh, and for a read issued during busy to reach its data phase before busy ends. Each check alternates the serial clock idle level between commands.

// File: rtl/nfs_pkg.sv
// Package: opcodes and status bit positions shared by the flash slave.
// Assumes 8-bit opcodes and a status byte with busy at bit 0, latch at bit 1.
package nfs_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_SERS = 8'h20;
    localparam logic [7:0] OP_BERS = 8'hD8;
    localparam logic [7:0] OP_CERS = 8'hC7;

    localparam int ST_BUSY = 0;
    localparam int ST_WEL  = 1;

    // True for opcodes that modify the array and need the latch.
    function automatic logic op_needs_wel(input logic [7:0] op);
        return (op == OP_PROG) || (op == OP_SERS) || (op == OP_BERS) || (op == OP_CERS);
    endfunction
endpackage

// File: rtl/nfs_serdes.sv
// Module: SPI serialiser/deserialiser in the system clock domain.
// Synchronises sck, cs_n and di with two flops each and detects sck edges.
// Receives bytes on rising edges and shifts tx bytes out on falling edges.
// A falling edge at a byte boundary loads tx_byte. That makes the first bit
// valid before the next rising edge in both clock idle levels.
// Assumes each sck phase lasts at least 5 system clocks, and that cs_n
// changes at least 2 system clocks away from any sck edge.
module nfs_serdes (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       di,
    input  logic [7:0] tx_byte,
    output logic       sel,
    output logic       cs_end,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       do_bit
);
    logic [2:0] sck_s;
    logic [2:0] cs_s;
    logic [1:0] di_s;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sr;
    logic [7:0] tx_sr;
    logic       rise, fall;

    // Two-flop synchronisers plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_s <= '0;
            cs_s  <= '1;
            di_s  <= '0;
        end else begin
            sck_s <= {sck_s[1:0], sck};
            cs_s  <= {cs_s[1:0], cs_n};
            di_s  <= {di_s[0], di};
        end
    end

    assign sel    = ~cs_s[1];
    assign cs_end = ~cs_s[2] & cs_s[1];
    assign rise   = sck_s[1] & ~sck_s[2] & sel;
    assign fall   = ~sck_s[1] & sck_s[2] & sel;

    // Receive path: count bits and present each completed byte for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sr    <= '0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (!sel) begin
                bit_cnt <= '0;
            end else if (rise) begin
                rx_sr   <= {rx_sr[5:0], di_s[1]};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= {rx_sr, di_s[1]};
                end
            end
        end
    end

    // Transmit path: load at a byte boundary, otherwise shift left on each fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (!sel) begin
            tx_sr <= '0;
        end else if (fall) begin
            tx_sr <= (bit_cnt == 3'd0) ? tx_byte : {tx_sr[6:0], 1'b0};
        end
    end

    assign do_bit = sel & tx_sr[7];

    // R2
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !fall) |=> $stable(tx_sr));
    // R2
    bitcnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_end |=> (bit_cnt == 3'd0));
endmodule

// File: rtl/nfs_ctrl.sv
// Module: command decoder, write-enable latch and busy timer.
// Decodes the opcode, assembles the 3-byte address and walks the read or
// program address. At select release it commits write enable or starts a
// busy period. An erase, if one is pending, is issued as a one-clock strobe
// when busy ends.
// Assumes PAGE_W < SECTOR_W < BLOCK_W < ADDR_W <= 24 and BUSY_CYCLES >= 1.
module nfs_ctrl
    import nfs_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int PAGE_W      = 3,
    parameter int SECTOR_W    = 5,
    parameter int BLOCK_W     = 8,
    parameter int BUSY_CYCLES = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              cs_end,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic [7:0]        rd_data,
    output logic [7:0]        tx_byte,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              wr_en,
    output logic [7:0]        wr_data,
    output logic              ers_en,
    output logic [ADDR_W-1:0] ers_base,
    output logic [ADDR_W-1:0] ers_mask
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [ADDR_W-1:0] SEC_MASK = ADDR_W'((1 << SECTOR_W) - 1);
    localparam logic [ADDR_W-1:0] BLK_MASK = ADDR_W'((1 << BLOCK_W) - 1);
    localparam logic [ADDR_W-1:0] ALL_MASK = '1;

    logic [7:0]        opcode;
    logic [2:0]        idx;
    logic              cmd_ok;
    logic [23:0]       addr_sh;
    logic [23:0]       addr_nxt;
    logic [ADDR_W-1:0] cur;
    logic              busy, wel, ers_pend;
    logic [CNT_W-1:0]  cnt;
    logic [7:0]        status;

    assign addr_nxt = {addr_sh[15:0], rx_byte};
    assign status   = {6'b0, wel, busy};

    // Opcode capture, address assembly and address walking per received byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode  <= '0;
            idx     <= '0;
            cmd_ok  <= 1'b0;
            addr_sh <= '0;
            cur     <= '0;
        end else if (!sel) begin
            idx    <= '0;
            cmd_ok <= 1'b0;
        end else if (rx_valid) begin
            if (idx != 3'd5) idx <= idx + 3'd1;
            if (idx == 3'd0) begin
                opcode <= rx_byte;
                cmd_ok <= busy ? (rx_byte == OP_RDSR) : (!op_needs_wel(rx_byte) || wel);
            end else if (idx <= 3'd3) begin
                addr_sh <= addr_nxt;
                if (idx == 3'd3) cur <= addr_nxt[ADDR_W-1:0];
            end else if (opcode == OP_READ) begin
                cur <= cur + 1'b1;
            end else if (opcode == OP_PROG) begin
                cur <= {cur[ADDR_W-1:PAGE_W], cur[PAGE_W-1:0] + 1'b1};
            end
        end
    end

    assign mem_addr = cur;
    assign wr_en    = rx_valid && sel && cmd_ok && (opcode == OP_PROG) && (idx >= 3'd4);
    assign wr_data  = rx_byte;

    // Output byte choice for the next byte boundary.
    always_comb begin
        tx_byte = 8'h00;
        if (cmd_ok && opcode == OP_RDSR)                    tx_byte = status;
        else if (cmd_ok && opcode == OP_READ && idx >= 3'd4) tx_byte = rd_data;
    end

    // Commit at select release; count the busy period; issue the erase at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            wel      <= 1'b0;
            ers_pend <= 1'b0;
            ers_en   <= 1'b0;
            cnt      <= '0;
            ers_base <= '0;
            ers_mask <= '0;
        end else begin
            ers_en <= 1'b0;
            if (busy) begin
                if (cnt == CNT_W'(1)) begin
                    busy   <= 1'b0;
                    wel    <= 1'b0;
                    ers_en <= ers_pend;
                end
                cnt <= cnt - 1'b1;
            end else if (cs_end && cmd_ok) begin
                ers_base <= cur;
                cnt      <= CNT_W'(BUSY_CYCLES);
                unique case (opcode)
                    OP_WREN: wel <= 1'b1;
                    OP_PROG: if (idx == 3'd5) begin busy <= 1'b1; ers_pend <= 1'b0; end
                    OP_SERS: if (idx == 3'd4) begin busy <= 1'b1; ers_pend <= 1'b1; ers_mask <= SEC_MASK; end
                    OP_BERS: if (idx == 3'd4) begin busy <= 1'b1; ers_pend <= 1'b1; ers_mask <= BLK_MASK; end
                    OP_CERS: if (idx == 3'd1) begin busy <= 1'b1; ers_pend <= 1'b1; ers_mask <= ALL_MASK; end
                    default: ;
                endcase
            end
        end
    end

    // R7
    wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel));
    // R8
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);
    // R9
    busy_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_en);
    // R6
    erase_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ers_en |-> ($past(busy) && !busy));
endmodule

// File: rtl/nfs_array.sv
// Module: byte storage with NOR semantics.
// Reads are asynchronous. A program write ANDs the data into the stored
// byte. A range erase sets to FFh every byte whose address matches ers_base
// outside ers_mask. Reset fills the array with FFh.
// Assumes the controller never raises wr_en and ers_en in the same cycle.
module nfs_array #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        rd_data,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              ers_en,
    input  logic [ADDR_W-1:0] ers_base,
    input  logic [ADDR_W-1:0] ers_mask
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0]        mem [DEPTH];
    logic [ADDR_W-1:0] chk_addr;
    logic [7:0]        chk_old;

    assign rd_data = mem[addr];

    // Array update: reset fill, range erase, or AND-program of one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (ers_en) begin
            for (int i = 0; i < DEPTH; i++)
                if ((ADDR_W'(i) & ~ers_mask) == (ers_base & ~ers_mask)) mem[i] <= 8'hFF;
        end else if (wr_en) begin
            mem[addr] <= mem[addr] & wr_data;
        end
    end

    // Assertion helper: address and previous contents of the last write slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_addr <= '0;
            chk_old  <= '0;
        end else begin
            chk_addr <= addr;
            chk_old  <= mem[addr];
        end
    end

    // R5
    no_set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((mem[chk_addr] & ~chk_old) == 8'h00));
    // R6
    erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ers_en |=> (mem[ers_base] == 8'hFF));
    // R9
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ers_en |-> !wr_en);
endmodule

// File: rtl/nor_flash_spi.sv
// Module: top of the SPI NOR flash slave.
// Connects the serial front end, the command controller and the array.
// Assumes the system clock runs at least 10 times faster than the serial clock.
module nor_flash_spi #(
    parameter int ADDR_W      = 9,
    parameter int PAGE_W      = 3,
    parameter int SECTOR_W    = 5,
    parameter int BLOCK_W     = 8,
    parameter int BUSY_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_di,
    output logic spi_do
);
    logic              sel, cs_end, rx_valid, wr_en, ers_en;
    logic [7:0]        rx_byte, tx_byte, rd_data, wr_data;
    logic [ADDR_W-1:0] mem_addr, ers_base, ers_mask;

    nfs_serdes u_serdes (
        .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .di(spi_di),
        .tx_byte(tx_byte), .sel(sel), .cs_end(cs_end), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .do_bit(spi_do)
    );

    nfs_ctrl #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECTOR_W(SECTOR_W),
        .BLOCK_W(BLOCK_W), .BUSY_CYCLES(BUSY_CYCLES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sel(sel), .cs_end(cs_end), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rd_data(rd_data), .tx_byte(tx_byte), .mem_addr(mem_addr),
        .wr_en(wr_en), .wr_data(wr_data), .ers_en(ers_en), .ers_base(ers_base),
        .ers_mask(ers_mask)
    );

    nfs_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n), .addr(mem_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_data(wr_data), .ers_en(ers_en), .ers_base(ers_base),
        .ers_mask(ers_mask)
    );
endmodule

// File: tb/nor_flash_spi_tb_top.sv
// Bench: drives SPI commands in both clock idle levels and compares every
// returned byte against an arithmetic model of the array.
module nor_flash_spi_tb_top;
    localparam int AW = 9, PW = 3, SW = 5, BW = 8, BUSY = 400;
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = 5;

    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, di = 1'b0;
    logic do_w;
    logic mode3 = 1'b0;
    bit   done  = 1'b0;
    int   n_vec = 0, n_bad = 0;
    logic [7:0] model [DEPTH];
    logic [7:0] r;

    always #4 clk = ~clk;

    nor_flash_spi #(.ADDR_W(AW), .PAGE_W(PW), .SECTOR_W(SW), .BLOCK_W(BW),
                    .BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_di(di), .spi_do(do_w));

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %02h exp %02h", req, got, exp);
        end
    endtask

    task automatic cs_on();
        sck = mode3; wait_clk(3); cs_n = 1'b0; wait_clk(HALF);
    endtask

    task automatic cs_off();
        if (!mode3) begin sck = 1'b0; wait_clk(HALF); end
        cs_n = 1'b1; wait_clk(8);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0; di = tx[i]; wait_clk(HALF);
            rx[i] = do_w; sck = 1'b1; wait_clk(HALF);
        end
    endtask

    task automatic send_addr(input int a);
        logic [7:0] x;
        xfer(8'(a >> 16), x); xfer(8'(a >> 8), x); xfer(8'(a), x);
    endtask

    task automatic op_only(input logic [7:0] op);
        logic [7:0] x;
        cs_on(); xfer(op, x); cs_off();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] x;
        cs_on(); xfer(8'h05, x); xfer(8'h00, s); cs_off();
    endtask

    function automatic logic [7:0] pat(input int a, input int seed);
        return 8'((a * 37) ^ (seed * 91) ^ 8'hA5);
    endfunction

    task automatic prog(input int a, input int n, input int seed, input bit upd);
        logic [7:0] x, d;
        int idx;
        cs_on(); xfer(8'h02, x); send_addr(a);
        for (int k = 0; k < n; k++) begin
            idx = (a & (DEPTH - 8)) | ((a + k) & 7);
            d = pat(idx, seed);
            xfer(d, x);
            if (upd) model[idx] = model[idx] & d;
        end
        cs_off();
    endtask

    task automatic erase(input logic [7:0] op, input int a, input int mw, input bit upd);
        logic [7:0] x;
        cs_on(); xfer(op, x); send_addr(a); cs_off();
        if (upd)
            for (int i = 0; i < DEPTH; i++)
                if ((i >> mw) == ((a % DEPTH) >> mw)) model[i] = 8'hFF;
    endtask

    task automatic read_chk(input int a, input int n, input string req);
        logic [7:0] x, q;
        cs_on(); xfer(8'h03, x); send_addr(a);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, q);
            chk(req, q, model[(a + k) % DEPTH]);
        end
        cs_off();
    endtask

    // R8: poll status until not busy, then expect 00h (latch cleared too).
    task automatic wait_ready();
        logic [7:0] s;
        s = 8'h01;
        for (int t = 0; t < 40 && s[0]; t++) rdsr(s);
        chk("R8 ready", s, 8'h00);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        logic [7:0] x, s1, s7;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        wait_clk(5); rst_n = 1'b1; wait_clk(5);

        // R1: reset status and contents
        rdsr(r); chk("R1 status", r, 8'h00);
        read_chk(0, 16, "R1 contents");
        // R2: idle-high clock gives the same status
        mode3 = 1'b1; rdsr(r); chk("R2 mode3 status", r, 8'h00); mode3 = 1'b0;

        // R7: program without latch is ignored
        prog(16, 4, 1, 1'b0);
        read_chk(16, 8, "R7 prog ignored");
        rdsr(r); chk("R7 not busy", r, 8'h00);

        // R3: write enable sets bit 1, seen in both idle levels
        op_only(8'h06);
        rdsr(r); chk("R3 wel", r, 8'h02);
        mode3 = 1'b1; rdsr(r); chk("R2 mode3 wel", r, 8'h02); mode3 = 1'b0;

        // R10: short erase and data-less program are ignored
        cs_on(); xfer(8'h20, x); xfer(8'h00, x); xfer(8'h40, x); cs_off();
        rdsr(r); chk("R10 short erase", r, 8'h02);
        cs_on(); xfer(8'h02, x); send_addr(8); cs_off();
        rdsr(r); chk("R10 no data", r, 8'h02);

        // R5, R8, R9: one wrapping program per sector
        for (int s = 0; s < 16; s++) begin
            mode3 = s[0];
            if (s != 0) op_only(8'h06);
            prog(s * 32 + 13, 10, s, 1'b1);
            if (s == 3) begin
                // R9: read during busy returns 00h
                cs_on(); xfer(8'h03, x); send_addr(s * 32); xfer(8'h00, r); cs_off();
                chk("R9 read busy", r, 8'h00);
                wait_ready();
            end else if (s == 5) begin
                // R9: write enable during busy is ignored
                op_only(8'h06);
                wait_ready();
            end else begin
                cs_on(); xfer(8'h05, x); xfer(8'h00, s1);
                for (int j = 0; j < 5; j++) xfer(8'h00, x);
                xfer(8'h00, s7); cs_off();
                chk("R8 busy set", s1, 8'h03);
                chk("R8 busy done", s7, 8'h00);
            end
        end
        mode3 = 1'b0;

        // R5: second program only clears bits
        op_only(8'h06); prog(8, 8, 200, 1'b1); wait_ready();
        read_chk(8, 8, "R5 and");

        // R7: erase without latch is ignored
        erase(8'h20, 13, SW, 1'b0);
        rdsr(r); chk("R7 erase ignored", r, 8'h00);

        // R6: sector erase and block erase
        op_only(8'h06); erase(8'h20, 32'h6D, SW, 1'b1); wait_ready();
        mode3 = 1'b1;
        op_only(8'h06); erase(8'hD8, 32'h1A3, BW, 1'b1); wait_ready();

        // R10: erase with an extra byte is ignored, latch stays set
        op_only(8'h06);
        cs_on(); xfer(8'h20, x); send_addr(32'h2A); xfer(8'h00, x); cs_off();
        rdsr(r); chk("R10 long erase", r, 8'h02);

        // R4: full sweep with wrap, upper address bits ignored
        read_chk(32'h7E0000 | (DEPTH - 8), DEPTH + 16, "R4 sweep");

        // R6: chip erase
        mode3 = 1'b0;
        cs_on(); xfer(8'hC7, x); cs_off(); wait_ready();
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        read_chk(DEPTH - 20, 40, "R6 chip");

        done = 1'b1;
        report();
    end

    initial begin
        wait_clk(190000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            report();
        end
    end
endmodule